// File: doc/BRIEF.md
# Counter-Match and Pin-Match Wait Unit

This block holds a small processor's execute stage while a wait instruction is pending. It lets the stage go on the exact clock on which the wait condition turns true. The unit owns a free-running system counter that advances on every clock.

Three kinds of wait are supported:

- **Counter wait** ends only when that counter equals a target value exactly. If the target has already gone by, the wait lasts a full wrap of the counter. When a counter wait ends, the unit adds an operand delta to the target and presents the sum. Successive waits can then be chained to a fixed period.
- **Pin-equal wait** watches a masked pin vector and ends when the masked pins equal the masked target.
- **Pin-differ wait** watches the same masked pin vector and ends when the masked pins differ from the masked target.

The pins pass through a two-stage synchronizer before they are compared. Every wait has a fixed arm phase and a fixed drain phase, so the whole operation never takes less than five clocks. Apart from that fixed overhead, the release can fall on any clock, odd or even. The decoder reports the release through a one-clock done pulse.

Top module: `wait_unit`

## Requirements
- R1: `cnt_o` is 0 while reset is held and increases by exactly 1, modulo 2^CNT_W, on every clock after reset.
- R2: A counter wait (op 2'b00) releases only when the counter equals the latched target exactly. With start sampled while `cnt_o` = C and target T, where (T − C) mod 2^CNT_W ≥ 2, `done_o` is high in the cycle where `cnt_o` = T + 3.
- R3: A counter wait whose target is less than two counts ahead of the counter at start does not release early. It releases one full counter wrap (2^CNT_W clocks) later than the same arithmetic would give, with `done_o` again in the cycle where `cnt_o` = T + 3.
- R4: A pin-equal wait (op 2'b01) releases when (pins & mask) == (target[PIN_W-1:0] & mask). Changes on bits whose mask bit is 0 have no effect. A qualifying pin change driven while `cnt_o` = C gives `done_o` in the cycle where `cnt_o` = C + 5.
- R5: A pin-differ wait (op 2'b10) releases when (pins & mask) != (target & mask). It follows the same masking and the same five-clock pin-to-done latency as R4.
- R6: Every wait takes at least five clocks. When the condition already holds at start, `busy_o` is high for exactly 4 cycles and `done_o` follows in the cycle where `cnt_o` = C + 5. In general `busy_o` is high for ((T − C) mod 2^CNT_W) + 2 cycles, plus 2^CNT_W cycles when that difference is below 2.
- R7: `busy_o` rises in the cycle after start is accepted and falls in the cycle where `done_o` is high. `done_o` is a single-cycle pulse. After reset both are 0.
- R8: `start_i` asserted while `busy_o` is high is ignored. The running wait completes once with its own target, and no second `done_o` follows.
- R9: `next_target_o` is 0 after reset. After a counter wait it equals (target + delta) mod 2^CNT_W at `done_o`. After a pin wait it equals the target unchanged.
- R10: Op code 2'b11 behaves exactly as a counter wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a wait (accepted only while idle) |
| op_i | input | 2 | 00 counter, 01 pin-equal, 10 pin-differ, 11 counter |
| target_i | input | CNT_W | Counter target, or pin target in its low PIN_W bits |
| delta_i | input | CNT_W | Amount added to the target after a counter release |
| mask_i | input | PIN_W | Pin bits taking part in a pin wait |
| pins_i | input | PIN_W | Asynchronous input pins |
| busy_o | output | 1 | Stall to the execute stage |
| done_o | output | 1 | One-clock release pulse |
| next_target_o | output | CNT_W | Updated target after the wait |
| cnt_o | output | CNT_W | Free-running system counter |

## Verification
The bench chases the off-by-one timing of the release. It checks counter waits placed at the nearest reachable target, at odd distances and just behind the counter. A design that matched on greater-or-equal, or that skipped the arm stage, would release one or thousands of clocks early. Pin waits are driven with changes on masked-off bits first, then a real change, so a design that ignored the mask, or dropped a synchronizer stage, would release early or at the wrong count. A second start during a wait, and a delta that wraps the target, catch designs that relatch mid-wait, pulse done twice, or update the target on pin waits.

// File: rtl/wait_unit_pkg.sv
// Shared types for the wait unit: operation codes, controller states and
// a helper that says which operation codes select a counter wait.
package wait_unit_pkg;
    typedef enum logic [1:0] {
        OP_CNT     = 2'b00,
        OP_PIN_EQ  = 2'b01,
        OP_PIN_NE  = 2'b10,
        OP_CNT_ALT = 2'b11
    } wait_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT,
        ST_DRAIN
    } wait_state_e;

    function automatic logic op_is_count(wait_op_e op);
        return (op == OP_CNT) || (op == OP_CNT_ALT);
    endfunction
endpackage

// File: rtl/wait_sys_counter.sv
// Free-running system counter: clears on reset, then advances by one every
// clock and wraps modulo 2^CNT_W. Assumes nothing about its consumers.
module wait_sys_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Advance the counter on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/wait_pin_sync.sv
// Multi-stage synchronizer for the asynchronous pin vector. Assumes each pin
// is independent; its latency of STAGES clocks is part of the release timing.
module wait_pin_sync #(
    parameter int PIN_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    output logic [PIN_W-1:0] pins_o
);
    logic [PIN_W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= pins_i;
            end
        end else begin : g_next
            // Later stages copy the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign pins_o = stage_q[STAGES-1];
endmodule

// File: rtl/wait_match.sv
// Combinational condition evaluator: exact counter equality for counter
// waits, masked equality or inequality for pin waits. Assumes PIN_W <= CNT_W.
module wait_match
    import wait_unit_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PIN_W = 8
) (
    input  wait_op_e         op_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] tgt_i,
    input  logic [PIN_W-1:0] mask_i,
    input  logic [PIN_W-1:0] pins_i,
    output logic             hit_o
);
    logic cnt_eq;
    logic pin_eq;

    // Select the condition that the current operation waits for.
    always_comb begin
        cnt_eq = (cnt_i == tgt_i);
        pin_eq = ((pins_i ^ tgt_i[PIN_W-1:0]) & mask_i) == '0;
        unique case (op_i)
            OP_PIN_EQ: hit_o = pin_eq;
            OP_PIN_NE: hit_o = !pin_eq;
            default:   hit_o = cnt_eq;
        endcase
    end
endmodule

// File: rtl/wait_ctrl.sv
// Wait sequencer: latches a request when idle, spends one arm clock, polls
// the match every clock, then drains two clocks and pulses done. Assumes
// hit_i is valid in the wait state; requests while busy are dropped.
module wait_ctrl
    import wait_unit_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  wait_op_e         op_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic [CNT_W-1:0] delta_i,
    input  logic [PIN_W-1:0] mask_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] cnt_i,
    output wait_op_e         op_o,
    output logic [CNT_W-1:0] tgt_o,
    output logic [PIN_W-1:0] mask_o,
    output logic             busy_o,
    output logic             done_o
);
    wait_state_e      state_q;
    wait_op_e         op_q;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] delta_q;
    logic [PIN_W-1:0] mask_q;
    logic             drain_q;
    logic             done_q;

    // Step the wait sequence and update the target on a counter release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CNT;
            tgt_q   <= '0;
            delta_q <= '0;
            mask_q  <= '0;
            drain_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    op_q    <= op_i;
                    tgt_q   <= target_i;
                    delta_q <= delta_i;
                    mask_q  <= mask_i;
                    state_q <= ST_ARM;
                end
                ST_ARM: state_q <= ST_WAIT;
                ST_WAIT: if (hit_i) begin
                    if (op_is_count(op_q)) tgt_q <= tgt_q + delta_q;
                    drain_q <= 1'b0;
                    state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (drain_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                    drain_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign op_o   = op_q;
    assign tgt_o  = tgt_q;
    assign mask_o = mask_q;
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

    assert_exact_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && hit_i && op_is_count(op_q)) |-> cnt_i == tgt_q);
    assert_min_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o, 1) && $past(busy_o, 4));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_hold_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(op_q) && $stable(mask_q) && $stable(delta_q));
endmodule

// File: rtl/wait_unit.sv
// Top of the wait unit: system counter, pin synchronizer, condition
// evaluator and sequencer. Assumes PIN_W <= CNT_W and a single clock domain
// apart from pins_i.
module wait_unit
    import wait_unit_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic [CNT_W-1:0] delta_i,
    input  logic [PIN_W-1:0] mask_i,
    input  logic [PIN_W-1:0] pins_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] next_target_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt;
    logic [PIN_W-1:0] pins_sync;
    logic [CNT_W-1:0] tgt;
    logic [PIN_W-1:0] mask;
    wait_op_e         op_cur;
    logic             hit;

    wait_sys_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .cnt_o(cnt)
    );

    wait_pin_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .pins_o(pins_sync)
    );

    wait_match #(.CNT_W(CNT_W), .PIN_W(PIN_W)) u_match (
        .op_i(op_cur), .cnt_i(cnt), .tgt_i(tgt), .mask_i(mask),
        .pins_i(pins_sync), .hit_o(hit)
    );

    wait_ctrl #(.CNT_W(CNT_W), .PIN_W(PIN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(wait_op_e'(op_i)),
        .target_i(target_i), .delta_i(delta_i), .mask_i(mask_i), .hit_i(hit),
        .cnt_i(cnt), .op_o(op_cur), .tgt_o(tgt), .mask_o(mask),
        .busy_o(busy_o), .done_o(done_o)
    );

    assign next_target_o = tgt;
    assign cnt_o         = cnt;
endmodule

// File: tb/wait_unit_tb.sv
// Scoreboard bench: driver tasks push the expected counter value and next
// target at release; a monitor pops one item per done pulse and compares.
module wait_unit_tb;
    localparam int CNT_W      = 12;
    localparam int PIN_W      = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WRAP       = 1 << CNT_W;

    typedef struct {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] nt;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [1:0]       op_i = 2'b00;
    logic [CNT_W-1:0] target_i = '0;
    logic [CNT_W-1:0] delta_i = '0;
    logic [PIN_W-1:0] mask_i = '0;
    logic [PIN_W-1:0] pins_i = '0;
    logic             busy_o;
    logic             done_o;
    logic [CNT_W-1:0] next_target_o;
    logic [CNT_W-1:0] cnt_o;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    logic done_prev = 1'b0;
    exp_t sb_q[$];

    wait_unit #(.CNT_W(CNT_W), .PIN_W(PIN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .target_i(target_i), .delta_i(delta_i), .mask_i(mask_i),
        .pins_i(pins_i), .busy_o(busy_o), .done_o(done_o),
        .next_target_o(next_target_o), .cnt_o(cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each done pulse with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (done_prev) check("R7 done longer than one cycle", 1, 0);
            if (sb_q.size() == 0) begin
                check("R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " counter at done"}, int'(cnt_o), int'(e.cnt));
                check("R9 next target", int'(next_target_o), int'(e.nt));
                check("R7 busy low at done", int'(busy_o), 0);
            end
        end
        done_prev = rst_n && done_o;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Drive one request at the current negedge; returns at the next negedge.
    task automatic issue(logic [1:0] op, logic [CNT_W-1:0] tgt,
                         logic [CNT_W-1:0] dl, logic [PIN_W-1:0] msk);
        op_i = op; target_i = tgt; delta_i = dl; mask_i = msk;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Count busy cycles from the current negedge until done is seen.
    task automatic wait_done(output int nbusy);
        nbusy = 0;
        for (int i = 0; i < 3 * WRAP; i++) begin
            if (done_o) break;
            if (busy_o) nbusy++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // Counter wait at a given distance ahead of the counter.
    task automatic cnt_wait(logic [1:0] op, int offset, logic [CNT_W-1:0] dl, string req);
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] t;
        int nb;
        int exp_b;
        exp_t e;
        c = cnt_o;
        t = c + CNT_W'(offset);
        exp_b = offset + 2 + ((offset < 2) ? WRAP : 0);
        e.cnt = t + CNT_W'(3); e.nt = t + dl; e.req = req;
        sb_q.push_back(e);
        issue(op, t, dl, '0);
        wait_done(nb);
        check({req, " busy length"}, nb, exp_b);
    endtask

    initial begin
        int nb;
        exp_t e;
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] prev;
        repeat (3) @(negedge clk);
        check("R1 counter in reset", int'(cnt_o), 0);
        check("R7 busy in reset", int'(busy_o), 0);
        check("R7 done in reset", int'(done_o), 0);
        check("R9 next target in reset", int'(next_target_o), 0);
        rst_n = 1'b1;
        prev = cnt_o;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R1 counter step", int'(cnt_o), int'(prev + 1'b1));
            prev = cnt_o;
        end

        cnt_wait(2'b00, 2, 12'h010, "R6 nearest target");
        cnt_wait(2'b00, 37, 12'h005, "R2 odd distance");
        cnt_wait(2'b00, 1, 12'h020, "R3 missed target wraps");
        cnt_wait(2'b00, 10, 12'hFFF, "R9 delta wraps target");
        cnt_wait(2'b11, 9, 12'h003, "R10 code 11 counts");

        // R4: condition already true at start (masked-off bits differ).
        pins_i = 8'h35;
        repeat (4) @(negedge clk);
        c = cnt_o;
        e.cnt = c + CNT_W'(5); e.nt = 12'h0A5; e.req = "R4 immediate pin-equal";
        sb_q.push_back(e);
        issue(2'b01, 12'h0A5, 12'h111, 8'h0F);
        wait_done(nb);
        check("R6 pin wait busy length", nb, 4);

        // R4: masked-off pin changes must not release.
        pins_i = 8'h00;
        repeat (4) @(negedge clk);
        issue(2'b01, 12'h0A5, 12'h000, 8'h0F);
        repeat (4) @(negedge clk);
        pins_i = 8'hF0;
        repeat (8) @(negedge clk);
        check("R4 masked change ignored, still busy", int'(busy_o), 1);
        c = cnt_o;
        e.cnt = c + CNT_W'(5); e.nt = 12'h0A5; e.req = "R4 pin-equal latency";
        sb_q.push_back(e);
        pins_i = 8'hF5;
        wait_done(nb);

        // R5: pin-differ with a masked-off bit toggling first.
        pins_i = 8'h05;
        repeat (4) @(negedge clk);
        issue(2'b10, 12'h005, 12'h000, 8'h7F);
        repeat (4) @(negedge clk);
        pins_i = 8'h85;
        repeat (8) @(negedge clk);
        check("R5 masked change ignored, still busy", int'(busy_o), 1);
        c = cnt_o;
        e.cnt = c + CNT_W'(5); e.nt = 12'h005; e.req = "R5 pin-differ latency";
        sb_q.push_back(e);
        pins_i = 8'h84;
        wait_done(nb);

        // R8: a second start during a wait is dropped.
        c = cnt_o;
        e.cnt = c + CNT_W'(33); e.nt = c + CNT_W'(33); e.req = "R8 first wait intact";
        sb_q.push_back(e);
        issue(2'b00, c + CNT_W'(30), 12'h003, '0);
        @(negedge clk);
        issue(2'b01, 12'h000, 12'h000, 8'h00);
        wait_done(nb);
        repeat (10) @(negedge clk);
        check("R8 idle after ignored start", int'(busy_o), 0);
        check("R8 scoreboard drained", sb_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule